// File: doc/BRIEF.md
# Successive-Approximation Tuning-Word Tracker

This block produces the tuning word for a phase-accumulator synthesizer that sits in a closed measurement loop. A frequency comparator reports whether the synthesized frequency should go up or down, and gives an update pulse with each decision. After a start command the block runs a binary search. It begins at half of the largest usable word, applies a step of one quarter of that word, and halves the step after every decision. When the search is finished, it moves the word by exactly one count per decision.

In tracking, the word swings in a triangle around the true value. The block records the word at each high turning point and at each low turning point. Once it holds one of each, it reports their midpoint as the reading and pulses a valid strobe. Tracking goes on for as long as decisions arrive, so the reading follows slow drift of the input without starting a new search. A new start command always restarts the search from the half-maximum word.

Top module: `sa_tune_tracker`

## Requirements
- R1: After reset, the tuning word, both captured extremes and the midpoint are 0, `resultValid` is 0, and `mode` is 2'b00 (idle).
- R2: On a cycle with `start` high, in any mode and even when `decValid` is also high, the next cycle shows a tuning word of MAX_WORD/2, `mode` 2'b01 (search), both extremes and the midpoint at 0, and no result pulse.
- R3: In search, each decision adds the current step to the word when `decUp` is 1 and subtracts it when `decUp` is 0. The first step is MAX_WORD/4, and the step halves after every decision.
- R4: The decision that applies a step of 1 is the last one of the search. After it, `mode` becomes 2'b10 (track). With the default parameters the search takes 29 decisions.
- R5: In track, each decision moves the word by +1 when `decUp` is 1 and by -1 when `decUp` is 0.
- R6: The word saturates at 0 and at MAX_WORD (2^30 by default) and never wraps.
- R7: The word changes only on a cycle with `decValid` high or `start` high. While idle, decisions are ignored.
- R8: In track, a 0 decision that follows a 1 decision stores the word held before that decision into `fswHigh`. A 1 decision that follows a 0 decision stores it into `fswLow`. The previous decision may be the last search decision.
- R9: Each capture made after both a high and a low value have been stored since the last start updates `midWord` to floor((fswHigh+fswLow)/2). On that same cycle `resultValid` is high for exactly one cycle.
- R10: Tracking continues with no new search for as long as decisions keep arriving, so the word follows a moving input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a fresh search |
| decValid | input | 1 | Update pulse from the comparator |
| decUp | input | 1 | Comparator decision: 1 = raise the frequency |
| tuneWord | output | 32 | Tuning word sent to the synthesizer |
| mode | output | 2 | 00 idle, 01 search, 10 track |
| fswHigh | output | 32 | Last captured high turning point |
| fswLow | output | 32 | Last captured low turning point |
| midWord | output | 32 | Midpoint of the two extremes |
| resultValid | output | 1 | One-cycle pulse when a new reading is available |

## Verification
The bench uses the default 32-bit word with MAX_WORD = 2^30, so each search takes 29 decisions and a run can hold many complete measurements. With these values, a search of all-up decisions ends at MAX_WORD-1 and a search of all-down decisions ends at 1. One further tracking step in the same direction therefore reaches the upper or lower saturation limit. In the random tracking phases a comparator model steers the word toward a target and sometimes flips a decision. This produces triangles of varying width, and changing the target checks that the loop follows the input without restarting.

// File: rtl/sa_track_pkg.sv
package sa_track_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_SEARCH = 2'b01,
    MODE_TRACK  = 2'b10
  } modeT;

  // Strobes sent from the control to the datapath, at most one action per cycle
  typedef struct packed {
    logic load;      // load the start word and the first step
    logic srchStep;  // apply one binary-search step
    logic trkStep;   // apply one unit tracking step
  } strobeT;

endpackage

// File: rtl/sa_track_ctrl.sv
module sa_track_ctrl
  import sa_track_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   decValid,
  input  logic   stepIsOne,
  output modeT   modeQ,
  output strobeT strb
);

  modeT modeNext;

  always_comb begin
    strb          = '0;
    strb.load     = start;
    strb.srchStep = !start && decValid && (modeQ == MODE_SEARCH);
    strb.trkStep  = !start && decValid && (modeQ == MODE_TRACK);
  end

  always_comb begin
    modeNext = modeQ;
    if (start) begin
      modeNext = MODE_SEARCH;
    end else if (strb.srchStep && stepIsOne) begin
      modeNext = MODE_TRACK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) modeQ <= MODE_IDLE;
    else     modeQ <= modeNext;
  end

  // R4
  track_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_TRACK && $past(modeQ) != MODE_TRACK) |-> ($past(modeQ) == MODE_SEARCH && $past(decValid)));

  // R10
  track_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_TRACK && !start) |=> (modeQ == MODE_TRACK));

endmodule

// File: rtl/sa_track_dp.sv
module sa_track_dp
  import sa_track_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter logic [WORD_W-1:0] MAX_WORD = WORD_W'(1) << (WORD_W - 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strb,
  input  logic              decUp,
  output logic              stepIsOne,
  output logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] hiWord,
  output logic [WORD_W-1:0] loWord,
  output logic [WORD_W-1:0] midWord,
  output logic              resValid
);

  localparam logic [WORD_W-1:0] HALF_WORD  = MAX_WORD >> 1;
  localparam logic [WORD_W-1:0] START_STEP = MAX_WORD >> 2;
  localparam logic [WORD_W-1:0] ONE        = WORD_W'(1);

  logic [WORD_W-1:0] step;
  logic              lastUp;
  logic              gotHi;
  logic              gotLo;
  logic [WORD_W-1:0] delta;
  logic [WORD_W:0]   upSum;
  logic [WORD_W-1:0] upWord;
  logic [WORD_W-1:0] downWord;
  logic [WORD_W-1:0] nextWord;
  logic              hiTurn;
  logic              loTurn;
  logic [WORD_W:0]   midSumHi;
  logic [WORD_W:0]   midSumLo;

  assign stepIsOne = (step == ONE);

  // Step size for this decision: search step or unit step
  assign delta  = strb.srchStep ? step : ONE;
  assign upSum  = {1'b0, word} + {1'b0, delta};
  assign upWord = (upSum > {1'b0, MAX_WORD}) ? MAX_WORD : upSum[WORD_W-1:0];
  assign downWord = (delta > word) ? '0 : (word - delta);
  assign nextWord = decUp ? upWord : downWord;

  // Turning points, tracking only
  assign hiTurn = strb.trkStep && lastUp && !decUp;
  assign loTurn = strb.trkStep && !lastUp && decUp;

  assign midSumHi = {1'b0, word} + {1'b0, loWord};
  assign midSumLo = {1'b0, hiWord} + {1'b0, word};

  always_ff @(posedge clk) begin
    if (rst) begin
      word     <= '0;
      step     <= '0;
      lastUp   <= 1'b0;
      gotHi    <= 1'b0;
      gotLo    <= 1'b0;
      hiWord   <= '0;
      loWord   <= '0;
      midWord  <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= 1'b0;
      if (strb.load) begin
        word    <= HALF_WORD;
        step    <= START_STEP;
        lastUp  <= 1'b0;
        gotHi   <= 1'b0;
        gotLo   <= 1'b0;
        hiWord  <= '0;
        loWord  <= '0;
        midWord <= '0;
      end else if (strb.srchStep || strb.trkStep) begin
        word   <= nextWord;
        lastUp <= decUp;
        if (strb.srchStep) step <= step >> 1;
        if (hiTurn) begin
          hiWord <= word;
          gotHi  <= 1'b1;
          if (gotLo) begin
            midWord  <= midSumHi[WORD_W:1];
            resValid <= 1'b1;
          end
        end
        if (loTurn) begin
          loWord <= word;
          gotLo  <= 1'b1;
          if (gotHi) begin
            midWord  <= midSumLo[WORD_W:1];
            resValid <= 1'b1;
          end
        end
      end
    end
  end

  // R6
  word_range_chk: assert property (@(posedge clk) disable iff (rst)
    word <= MAX_WORD);

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.srchStep && !strb.trkStep) |=> $stable(word));

  // R2
  load_word_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (word == HALF_WORD && !resValid));

  // R5
  track_unit_chk: assert property (@(posedge clk) disable iff (rst)
    strb.trkStep |=> (word == $past(word) + ONE || word == $past(word) - ONE || word == $past(word)));

  // R9
  pair_order_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (hiWord >= loWord && midWord >= loWord && midWord <= hiWord));

endmodule

// File: rtl/sa_tune_tracker.sv
module sa_tune_tracker
  import sa_track_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter logic [WORD_W-1:0] MAX_WORD = WORD_W'(1) << (WORD_W - 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              decValid,
  input  logic              decUp,
  output logic [WORD_W-1:0] tuneWord,
  output logic [1:0]        mode,
  output logic [WORD_W-1:0] fswHigh,
  output logic [WORD_W-1:0] fswLow,
  output logic [WORD_W-1:0] midWord,
  output logic              resultValid
);

  modeT   modeQ;
  strobeT strb;
  logic   stepIsOne;

  sa_track_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .decValid  (decValid),
    .stepIsOne (stepIsOne),
    .modeQ     (modeQ),
    .strb      (strb)
  );

  sa_track_dp #(
    .WORD_W   (WORD_W),
    .MAX_WORD (MAX_WORD)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .decUp     (decUp),
    .stepIsOne (stepIsOne),
    .word      (tuneWord),
    .hiWord    (fswHigh),
    .loWord    (fswLow),
    .midWord   (midWord),
    .resValid  (resultValid)
  );

  assign mode = modeQ;

endmodule

// File: tb/test_sa_tune_tracker.sv
module test_sa_tune_tracker;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MAXW = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic decValid = 1'b0;
  logic decUp = 1'b0;
  logic [31:0] tuneWord;
  logic [1:0]  mode;
  logic [31:0] fswHigh;
  logic [31:0] fswLow;
  logic [31:0] midWord;
  logic        resultValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Bench model state, built from the requirements
  logic [31:0] mWord, mStep, mHi, mLo, mMid;
  logic [1:0]  mMode;
  logic        mLast, mGotHi, mGotLo, mValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  sa_tune_tracker i_sa_tune_tracker (
    .clk(clk), .rst(rst), .start(start), .decValid(decValid), .decUp(decUp),
    .tuneWord(tuneWord), .mode(mode), .fswHigh(fswHigh), .fswLow(fswLow),
    .midWord(midWord), .resultValid(resultValid)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] satUp(input logic [31:0] w, input logic [31:0] d);
    longint s = longint'(w) + longint'(d);
    return (s > longint'(MAXW)) ? MAXW : s[31:0];
  endfunction

  function automatic logic [31:0] satDn(input logic [31:0] w, input logic [31:0] d);
    return (d > w) ? 32'd0 : w - d;
  endfunction

  function automatic logic [31:0] avg(input logic [31:0] a, input logic [31:0] b);
    longint s = longint'(a) + longint'(b);
    return s[32:1];
  endfunction

  task automatic modelReset();
    mWord = 0; mStep = 0; mHi = 0; mLo = 0; mMid = 0; mMode = 2'b00;
    mLast = 0; mGotHi = 0; mGotLo = 0; mValid = 0;
  endtask

  task automatic modelStep(input bit s, input bit v, input bit d);
    mValid = 1'b0;
    if (s) begin
      mWord = MAXW >> 1; mStep = MAXW >> 2; mMode = 2'b01; mLast = 0;
      mGotHi = 0; mGotLo = 0; mHi = 0; mLo = 0; mMid = 0;
    end else if (v && mMode == 2'b01) begin
      mWord = d ? satUp(mWord, mStep) : satDn(mWord, mStep);
      if (mStep == 1) mMode = 2'b10;
      mStep = mStep >> 1;
      mLast = d;
    end else if (v && mMode == 2'b10) begin
      if (mLast && !d) begin
        mHi = mWord; mGotHi = 1;
        if (mGotLo) begin mMid = avg(mHi, mLo); mValid = 1; end
      end
      if (!mLast && d) begin
        mLo = mWord; mGotLo = 1;
        if (mGotHi) begin mMid = avg(mHi, mLo); mValid = 1; end
      end
      mWord = d ? satUp(mWord, 1) : satDn(mWord, 1);
      mLast = d;
    end
  endtask

  function automatic string wordTag();
    if (mMode == 2'b01) return "R3";
    if (mMode == 2'b10) return "R5";
    return "R7";
  endfunction

  // One clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit s, input bit v, input bit d);
    string tag;
    start = s; decValid = v; decUp = d;
    @(posedge clk);
    tag = (s) ? "R2" : wordTag();
    modelStep(s, v, d);
    @(negedge clk);
    start = 0; decValid = 0; decUp = 0;
    chk(tag, "tuneWord", tuneWord, mWord);
    chk("R4", "mode", mode, mMode);
    chk("R8", "fswHigh", fswHigh, mHi);
    chk("R8", "fswLow", fswLow, mLo);
    chk("R9", "midWord", midWord, mMid);
    chk("R9", "resultValid", resultValid, mValid);
  endtask

  task automatic searchWith(input logic [31:0] target);
    for (int i = 0; i < 29; i++) cyc(0, 1, mWord < target);
  endtask

  task automatic trackRandom(input int n, input logic [31:0] target);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(3) == 0) cyc(0, 0, 1'($urandom));
      else begin
        bit d = (mWord < target);
        if ($urandom_range(7) == 0) d = !d;
        cyc(0, 1, d);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] tgt;
    logic [31:0] held;
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "tuneWord", tuneWord, 0);
    chk("R1", "mode", mode, 0);
    chk("R1", "fswHigh", fswHigh, 0);
    chk("R1", "fswLow", fswLow, 0);
    chk("R1", "midWord", midWord, 0);
    chk("R1", "resultValid", resultValid, 0);

    // R7 decisions in idle are ignored
    for (int i = 0; i < 5; i++) cyc(0, 1, 1'(i));
    chk("R7", "idle word", tuneWord, 0);

    // R2 start beats a simultaneous decision
    cyc(1, 1, 1);
    chk("R2", "start word", tuneWord, 32'h2000_0000);
    chk("R2", "start mode", mode, 2'b01);

    // R3/R4 all-up search, then R6 upper saturation
    for (int i = 0; i < 29; i++) cyc(0, 1, 1);
    chk("R4", "mode after 29", mode, 2'b10);
    chk("R3", "all-up end", tuneWord, MAXW - 1);
    cyc(0, 1, 1);
    cyc(0, 1, 1);
    chk("R6", "upper sat", tuneWord, MAXW);
    cyc(0, 1, 0);
    chk("R8", "high at max", fswHigh, MAXW);

    // R6 lower saturation after an all-down search
    cyc(1, 0, 0);
    for (int i = 0; i < 29; i++) cyc(0, 1, 0);
    chk("R3", "all-down end", tuneWord, 1);
    cyc(0, 1, 0);
    cyc(0, 1, 0);
    chk("R6", "lower sat", tuneWord, 0);

    // Random measurements with triangular tracking
    for (int m = 0; m < 6; m++) begin
      tgt = $urandom_range(MAXW);
      cyc(1, 0, 0);
      searchWith(tgt);
      trackRandom(300, tgt);
      // R10 follow a moved input without restarting
      tgt = satUp(tgt, 32'($urandom_range(80)));
      trackRandom(300, tgt);
      chk("R10", "still tracking", mode, 2'b10);
    end

    // R7 gaps without decValid leave the word unchanged
    held = tuneWord;
    for (int i = 0; i < 4; i++) cyc(0, 0, 1);
    chk("R7", "hold word", tuneWord, held);

    // R2 start while tracking restarts the search
    cyc(1, 0, 0);
    chk("R2", "restart word", tuneWord, 32'h2000_0000);
    chk("R2", "restart mode", mode, 2'b01);
    chk("R2", "restart clears", fswHigh, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule